// File: doc/BRIEF.md
# Redundant-Channel Agreement Monitor with De-energize Trip

This block watches a pair of redundant controller channels that compute the same 12-bit result. When a compare strobe arrives, it checks whether the two results agree within a programmable absolute tolerance. If they agree and nothing has tripped, it forwards channel A's result to a registered output and energizes the output-enable line. Each channel also sends a heartbeat to a per-channel watchdog. A heartbeat that goes missing for too long means the channel's clock has drifted or the channel has stalled.

Two kinds of fault are dangerous and detected: disagreement at a strobe, and a watchdog expiry. Either one trips the block into its safe state. In that state the output-enable is low and the forwarded result is forced to zero. The trip holds until a clear input is pulsed. A configuration-integrity failure flag from outside is also logged. It is classified as a safe fault: it sets its own sticky bit, but it neither trips nor de-energizes the output.

Top module: `dual_chan_monitor`

## Requirements
- R1: After a synchronous reset, `out_en` is 0, `out_res` is 0, `fault_code` is 0 and `trip` is 0, so the default state is de-energized.
- R2: At a strobe with no trip pending, if |res_a - res_b| <= tol, the next clock edge loads `out_res` with res_a and sets `out_en` to 1. A difference exactly equal to tol counts as agreement, whichever channel is larger.
- R3: At a strobe, if |res_a - res_b| > tol, the next edge sets `trip` and fault_code bit 0 (mismatch), and drives `out_en` and `out_res` to 0.
- R4: The results are compared only in cycles where `cmp_strobe` is high. A disagreement in any other cycle has no effect on `out_res`, `out_en` or `fault_code`.
- R5: Each channel's watchdog reloads whenever that channel's heartbeat is high. After `wd_limit` consecutive edges without a heartbeat, the next edge sets fault_code bit 1 (channel A) or bit 2 (channel B) and trips, de-energizing the output.
- R6: `cfg_fail` sets fault_code bit 3 at the next edge. It does not set `trip`, and it does not change `out_en` or block forwarding.
- R7: Once tripped, a later agreeing strobe does not re-energize the output. `out_en` and `out_res` stay 0 and the fault code holds.
- R8: Fault code bits are sticky and accumulate: a later fault ORs its bit into the code, and no bit clears except on reset or clear.
- R9: A `clr` pulse clears `fault_code` and `trip`, keeps `out_en` at 0 and reloads both watchdogs. The next agreeing strobe re-energizes the output. `clr` takes priority over any fault in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear latched faults and trip |
| cmp_strobe | input | 1 | Compare and forward strobe |
| res_a | input | 12 | Channel A result |
| res_b | input | 12 | Channel B result |
| tol | input | 12 | Absolute agreement tolerance |
| hb_a | input | 1 | Channel A heartbeat |
| hb_b | input | 1 | Channel B heartbeat |
| wd_limit | input | 16 | Cycles without heartbeat before expiry |
| cfg_fail | input | 1 | Configuration-integrity check failed |
| out_res | output | 12 | Forwarded result, 0 when tripped |
| out_en | output | 1 | Output energize enable |
| fault_code | output | 4 | Sticky faults: bit0 mismatch, bit1 wd A, bit2 wd B, bit3 config |
| trip | output | 1 | Dangerous fault latched |

## Verification
The hardest case to reach is the exact cycle at which a watchdog expires. The bench restores the heartbeats through a clear, then holds one heartbeat low for a known count of edges. It confirms that the fault bit is still clear after `wd_limit` edges and set one edge later. Heartbeats are held high everywhere else, so no stray expiry can hide the boundary. Sticky accumulation is reached by letting a watchdog lapse while a mismatch trip is already latched.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int FC_W        = 4;
  localparam int FC_MISMATCH = 0;
  localparam int FC_WD_A     = 1;
  localparam int FC_WD_B     = 2;
  localparam int FC_CFG      = 3;
  localparam int N_CHAN      = 2;
endpackage

// File: rtl/dcm_compare.sv
module dcm_compare #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] tol,
  output logic              agree
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    if (a >= b) diff = a - b;
    else        diff = b - a;
    agree = (diff <= tol);
  end
endmodule

// File: rtl/dcm_watchdog.sv
module dcm_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             hb,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload || hb) cnt <= '0;
    else if (cnt < limit)    cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  AST_HB_RELOADS: assert property (@(posedge clk) disable iff (rst)
    hb |=> (cnt == '0)); // R5
endmodule

// File: rtl/dcm_fault_latch.sv
module dcm_fault_latch
  import dcm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [FC_W-1:0] set_vec,
  output logic [FC_W-1:0] code,
  output logic            tripped
);
  logic [FC_W-1:0] danger_mask;
  assign danger_mask = FC_W'((1 << FC_MISMATCH) | (1 << FC_WD_A) | (1 << FC_WD_B));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code    <= '0;
      tripped <= 1'b0;
    end else begin
      code    <= code | set_vec;
      tripped <= tripped | (|(set_vec & danger_mask));
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((code & $past(code)) == $past(code))); // R8
  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tripped && !clr) |=> tripped); // R7
endmodule

// File: rtl/dual_chan_monitor.sv
module dual_chan_monitor
  import dcm_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int WD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cmp_strobe,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  input  logic [DATA_W-1:0] tol,
  input  logic              hb_a,
  input  logic              hb_b,
  input  logic [WD_W-1:0]   wd_limit,
  input  logic              cfg_fail,
  output logic [DATA_W-1:0] out_res,
  output logic              out_en,
  output logic [FC_W-1:0]   fault_code,
  output logic              trip
);
  logic              agree;
  logic [N_CHAN-1:0] hb_vec;
  logic [N_CHAN-1:0] wd_exp;
  logic [FC_W-1:0]   set_vec;
  logic              danger_now;

  assign hb_vec = {hb_b, hb_a};

  dcm_compare #(.DATA_W(DATA_W)) u_cmp (
    .a(res_a), .b(res_b), .tol(tol), .agree(agree)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_wd
    dcm_watchdog #(.CNT_W(WD_W)) u_wd (
      .clk(clk), .rst(rst), .reload(clr), .hb(hb_vec[c]),
      .limit(wd_limit), .expired(wd_exp[c])
    );
  end

  always_comb begin
    set_vec              = '0;
    set_vec[FC_MISMATCH] = cmp_strobe && !agree;
    set_vec[FC_WD_A]     = wd_exp[0];
    set_vec[FC_WD_B]     = wd_exp[1];
    set_vec[FC_CFG]      = cfg_fail;
    danger_now           = set_vec[FC_MISMATCH] | set_vec[FC_WD_A] | set_vec[FC_WD_B];
  end

  dcm_fault_latch u_latch (
    .clk(clk), .rst(rst), .clr(clr), .set_vec(set_vec),
    .code(fault_code), .tripped(trip)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_res <= '0;
      out_en  <= 1'b0;
    end else if (trip || danger_now) begin
      out_res <= '0;
      out_en  <= 1'b0;
    end else if (cmp_strobe && agree) begin
      out_res <= res_a;
      out_en  <= 1'b1;
    end
  end

  AST_TRIP_DEENERGIZED: assert property (@(posedge clk) disable iff (rst)
    trip |-> (!out_en && out_res == '0)); // R3
  AST_MISMATCH_TRIPS: assert property (@(posedge clk) disable iff (rst)
    (cmp_strobe && !agree && !clr) |=> (trip && fault_code[FC_MISMATCH])); // R3
  AST_WD_TRIPS: assert property (@(posedge clk) disable iff (rst)
    ((|wd_exp) && !clr) |=> (trip && !out_en)); // R5
  AST_CFG_LOGGED: assert property (@(posedge clk) disable iff (rst)
    (cfg_fail && !clr) |=> fault_code[FC_CFG]); // R6
  AST_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (cmp_strobe && agree && !trip && !(|wd_exp) && !clr)
      |=> (out_en && out_res == $past(res_a))); // R2
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fault_code == '0 && !trip && !out_en)); // R9
endmodule

// File: tb/tb_dual_chan_monitor.sv
module tb_dual_chan_monitor;
  logic        clk = 1'b0;
  logic        rst, clr, cmp_strobe, hb_a, hb_b, cfg_fail;
  logic [11:0] res_a, res_b, tol, out_res;
  logic [15:0] wd_limit;
  logic        out_en, trip;
  logic [3:0]  fault_code;
  int n_chk = 0;
  int n_fail = 0;
  localparam int LIM = 8;

  always #10 clk = ~clk;

  dual_chan_monitor dut (
    .clk(clk), .rst(rst), .clr(clr), .cmp_strobe(cmp_strobe),
    .res_a(res_a), .res_b(res_b), .tol(tol), .hb_a(hb_a), .hb_b(hb_b),
    .wd_limit(wd_limit), .cfg_fail(cfg_fail), .out_res(out_res),
    .out_en(out_en), .fault_code(fault_code), .trip(trip)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input int a, input int b);
    res_a = 12'(a); res_b = 12'(b); cmp_strobe = 1'b1;
    step();
    cmp_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic t_reset();
    check(out_en == 0, "R1 out_en", out_en, 0);
    check(out_res == 0, "R1 out_res", out_res, 0);
    check(fault_code == 0 && trip == 0, "R1 faults", fault_code, 0);
  endtask

  task automatic t_agree();
    strobe(100, 100);
    check(out_en == 1 && out_res == 100, "R2 equal", out_res, 100);
    strobe(200, 205);
    check(out_res == 200 && fault_code == 0, "R2 b-a=tol", out_res, 200);
    strobe(300, 295);
    check(out_res == 300 && out_en == 1, "R2 a-b=tol", out_res, 300);
  endtask

  task automatic t_no_strobe();
    res_a = 12'd0; res_b = 12'd4000;
    step(); step();
    check(out_res == 300 && out_en == 1, "R4 out held", out_res, 300);
    check(fault_code == 0 && trip == 0, "R4 no fault", fault_code, 0);
  endtask

  task automatic t_cfg();
    cfg_fail = 1'b1; step(); cfg_fail = 1'b0;
    check(fault_code == 8, "R6 cfg bit3", fault_code, 8);
    check(trip == 0 && out_en == 1, "R6 no trip", trip, 0);
    strobe(50, 50);
    check(out_res == 50 && out_en == 1, "R6 still forwards", out_res, 50);
    pulse_clr();
  endtask

  task automatic t_mismatch();
    strobe(60, 60);
    strobe(1000, 1006);
    check(trip == 1 && fault_code == 1, "R3 mismatch code", fault_code, 1);
    check(out_en == 0 && out_res == 0, "R3 de-energized", out_res, 0);
  endtask

  task automatic t_latched();
    strobe(7, 7);
    check(out_en == 0 && out_res == 0, "R7 stays off", out_en, 0);
    check(fault_code == 1 && trip == 1, "R7 code held", fault_code, 1);
  endtask

  task automatic t_sticky();
    hb_a = 1'b0;
    repeat (LIM + 1) step();
    hb_a = 1'b1;
    check(fault_code == 3, "R8 accumulate", fault_code, 3);
  endtask

  task automatic t_clear();
    pulse_clr();
    check(fault_code == 0 && trip == 0, "R9 cleared", fault_code, 0);
    check(out_en == 0, "R9 stays off", out_en, 0);
    strobe(42, 40);
    check(out_en == 1 && out_res == 42, "R9 re-energize", out_res, 42);
  endtask

  task automatic t_wd_boundary();
    pulse_clr();
    strobe(11, 11);
    hb_b = 1'b0;
    repeat (LIM) step();
    check(fault_code == 0 && out_en == 1, "R5 not yet expired", fault_code, 0);
    step();
    hb_b = 1'b1;
    check(fault_code == 4 && trip == 1, "R5 wd B expired", fault_code, 4);
    check(out_en == 0, "R5 de-energized", out_en, 0);
    pulse_clr();
    hb_a = 1'b0;
    repeat (LIM + 1) step();
    hb_a = 1'b1;
    check(fault_code == 2 && trip == 1, "R5 wd A expired", fault_code, 2);
    pulse_clr();
  endtask

  task automatic t_clr_priority();
    clr = 1'b1; res_a = 12'd0; res_b = 12'd900; cmp_strobe = 1'b1;
    step();
    clr = 1'b0; cmp_strobe = 1'b0;
    check(fault_code == 0 && trip == 0, "R9 clr priority", fault_code, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; cmp_strobe = 1'b0; hb_a = 1'b1; hb_b = 1'b1;
    cfg_fail = 1'b0; res_a = '0; res_b = '0; tol = 12'd5; wd_limit = 16'(LIM);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_agree();
    t_no_strobe();
    t_cfg();
    t_mismatch();
    t_latched();
    t_sticky();
    t_clear();
    t_wd_boundary();
    t_clr_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule